// File: doc/BRIEF.md
# Interrupt Acknowledge Type Responder

This block sits between a set of device request lines and a processor's level-sensitive interrupt input. Every request line that pulses or stays high is remembered in a pending register. While any line is pending, the block drives a single interrupt request to the processor. The processor answers with a handshake of two active-low acknowledge strobes, and the block returns an interrupt type byte on a bus that it drives only for part of the second strobe. The type byte is an 8-bit value. Its upper bits come from a programmable base register and its lower bits give the index of the winning line.

The first strobe freezes the winner and the complete type byte. Any request, or any write to the base register, that arrives after that strobe only affects later handshakes. At the end of the second strobe the winning line is cleared from the pending register. The interrupt request then falls if no other line is pending and stays high if one is. If the first strobe finds nothing pending, the block answers with the lowest-priority index so that a spurious acknowledge still gets a well-defined type.

Top module: `irq_type_responder`

## Requirements
- R1: After reset, irq_o is 0, data_oe_o is 0, data_o is 0 and the base register holds 8'h08. With the default base, a spurious handshake therefore returns 8'h0F.
- R2: A line that is high at a clock edge becomes pending. While any line is pending, irq_o is 1. irq_o stays 1 until a handshake clears the line, even after the request input has dropped.
- R3: The pending line with the lowest index wins, so line 0 has the highest priority. Bits [2:0] of the returned type hold the winning index.
- R4: The returned type is {base[7:3], index}. A write with base_we_i stores only base_i[7:3]. Bits base_i[2:0] are ignored.
- R5: During the first acknowledge strobe and the gap between the strobes, data_oe_o is 0 and data_o is 0. data_oe_o is 1 only while the second strobe is low. It returns to 0 once the strobe rises.
- R6: The winner index and the base bits are frozen when the first strobe falls. Requests raised later, and base writes made later, do not change the type returned by the same handshake.
- R7: At the end of the second strobe the winning line leaves the pending set. irq_o falls on the clock edge where the strobe is seen high, unless another line is still pending.
- R8: If no line is pending when the first strobe falls, the returned index is 7 (the lowest priority). No pending line is cleared in that case.
- R9: Several pending lines are served one per handshake, in ascending index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Device request lines; index 0 has the highest priority |
| ack_n_i | input | 1 | Active-low acknowledge strobe from the processor |
| base_we_i | input | 1 | Write strobe for the base register |
| base_i | input | 8 | Base value; only bits [7:3] are stored |
| irq_o | output | 1 | Level interrupt request to the processor |
| data_o | output | 8 | Type byte; zero when not enabled |
| data_oe_o | output | 1 | Bus drive enable; high during the second strobe |

## Verification
The bench builds the block with eight lines, an 8-bit type and no acknowledge synchronizer, so each strobe edge acts on the next clock edge. With eight lines there are only 255 non-empty request patterns, so the bench sweeps all of them. For each pattern it changes the base and drains the pending set one handshake at a time. That covers every priority ordering and every index value that can appear in the type byte. Separate passes cover the bus being quiet during the first strobe, late requests and late base writes made between the strobes, and a spurious acknowledge.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;

   typedef enum logic [1:0] {
      HS_IDLE   = 2'd0,
      HS_FIRST  = 2'd1,
      HS_GAP    = 2'd2,
      HS_SECOND = 2'd3
   } hs_state_e;

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int unsigned NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] req_i,
   input  logic [NUM_LINES-1:0] clr_i,
   output logic [NUM_LINES-1:0] pend_o
);

   logic [NUM_LINES-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q | req_i) & ~clr_i;
   end

   assign pend_o = pend_q;

   AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_i)); // R7
   AST_CLR_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_i) |-> ((clr_i & pend_q) == clr_i)); // R7

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned IDX_W     = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] pend_i,
   output logic [IDX_W-1:0]     idx_o,
   output logic                 any_o
);

   localparam logic [IDX_W-1:0] LOWEST_PRIO = IDX_W'(NUM_LINES - 1);

   always_comb begin
      idx_o = LOWEST_PRIO;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (pend_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign any_o = |pend_i;

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
   import irq_resp_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_n_i,
   output logic cap_o,
   output logic done_o,
   output logic drive_o
);

   logic      ack_s;
   logic      ack_prev_q;
   logic      fall;
   hs_state_e st_q, st_d;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign ack_s = ack_n_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-1:0], ack_n_i} >> 0;
         end
         assign ack_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_prev_q <= 1'b1;
      else        ack_prev_q <= ack_s;
   end

   assign fall = ack_prev_q & ~ack_s;

   always_comb begin
      st_d   = st_q;
      cap_o  = 1'b0;
      done_o = 1'b0;
      unique case (st_q)
         HS_IDLE:   if (fall) begin st_d = HS_FIRST; cap_o = 1'b1; end
         HS_FIRST:  if (ack_s) st_d = HS_GAP;
         HS_GAP:    if (fall) st_d = HS_SECOND;
         HS_SECOND: if (ack_s) begin st_d = HS_IDLE; done_o = 1'b1; end
         default:   st_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= HS_IDLE;
      else        st_q <= st_d;
   end

   assign drive_o = ~ack_s & ((st_q == HS_GAP) | (st_q == HS_SECOND));

   AST_DONE_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(drive_o)); // R5

endmodule

// File: rtl/irq_type_responder.sv
module irq_type_responder #(
   parameter int unsigned NUM_LINES   = 8,
   parameter int unsigned TYPE_W      = 8,
   parameter int unsigned SYNC_STAGES = 0,
   parameter logic [7:0]  BASE_RST    = 8'h08
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] req_i,
   input  logic                 ack_n_i,
   input  logic                 base_we_i,
   input  logic [TYPE_W-1:0]    base_i,
   output logic                 irq_o,
   output logic [TYPE_W-1:0]    data_o,
   output logic                 data_oe_o
);

   localparam int unsigned IDX_W  = $clog2(NUM_LINES);
   localparam int unsigned BASE_W = TYPE_W - IDX_W;

   generate
      if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES) begin : g_bad_lines
         $error("NUM_LINES must be a power of two, at least 2");
      end
      if (TYPE_W <= IDX_W || TYPE_W > 8) begin : g_bad_type
         $error("TYPE_W must exceed the index width and be at most 8");
      end
      if (SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 3");
      end
   endgenerate

   logic [NUM_LINES-1:0] pend;
   logic [NUM_LINES-1:0] clr_vec;
   logic [IDX_W-1:0]     pick_idx;
   logic                 pick_any;
   logic                 cap, done, drive;
   logic [BASE_W-1:0]    base_q;
   logic [IDX_W-1:0]     win_idx_q;
   logic                 win_vld_q;
   logic [TYPE_W-1:0]    type_q;

   irq_req_latch #(.NUM_LINES(NUM_LINES)) u_latch (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr_vec), .pend_o(pend)
   );

   irq_prio_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick (
      .pend_i(pend), .idx_o(pick_idx), .any_o(pick_any)
   );

   irq_ack_seq #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
      .clk(clk), .rst_n(rst_n), .ack_n_i(ack_n_i),
      .cap_o(cap), .done_o(done), .drive_o(drive)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         base_q <= BASE_RST[TYPE_W-1:IDX_W];
      else if (base_we_i) base_q <= base_i[TYPE_W-1:IDX_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_idx_q <= '0;
         win_vld_q <= 1'b0;
         type_q    <= '0;
      end else if (cap) begin
         win_idx_q <= pick_idx;
         win_vld_q <= pick_any;
         type_q    <= {base_q, pick_idx};
      end
   end

   assign clr_vec   = (done && win_vld_q) ? (NUM_LINES'(1) << win_idx_q) : '0;
   assign irq_o     = |pend;
   assign data_oe_o = drive;
   assign data_o    = drive ? type_q : '0;

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !done) |=> irq_o); // R2
   AST_TYPE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe_o && $past(data_oe_o)) |-> $stable(data_o)); // R6
   AST_SPURIOUS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe_o && !win_vld_q) |-> (data_o[IDX_W-1:0] == IDX_W'(NUM_LINES - 1))); // R8
   AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !data_oe_o |-> (data_o == '0)); // R5

endmodule

// File: tb/irq_type_responder_bench.sv
module irq_type_responder_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req = '0;
   logic       ack_n = 1'b1;
   logic       base_we = 1'b0;
   logic [7:0] base_v = '0;
   logic       irq;
   logic [7:0] data;
   logic       oe;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   irq_type_responder u_irq_type_responder (
      .clk(clk), .rst_n(rst_n), .req_i(req), .ack_n_i(ack_n),
      .base_we_i(base_we), .base_i(base_v),
      .irq_o(irq), .data_o(data), .data_oe_o(oe)
   );

   task automatic check(input string rq, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic write_base(input logic [7:0] v);
      @(negedge clk); base_we = 1'b1; base_v = v;
      @(negedge clk); base_we = 1'b0; base_v = '0;
   endtask

   task automatic raise(input logic [7:0] m);
      @(negedge clk); req = m;
      @(negedge clk); req = '0;
   endtask

   // first strobe plus the gap; reports whether the bus was ever driven
   task automatic hs_first(output bit noisy);
      noisy = 1'b0;
      @(negedge clk); ack_n = 1'b0; #1 noisy |= (oe || data != 0);
      @(negedge clk); #1 noisy |= (oe || data != 0);
      @(negedge clk); ack_n = 1'b1; #1 noisy |= (oe || data != 0);
      @(negedge clk); #1 noisy |= (oe || data != 0);
   endtask

   task automatic hs_second(output logic [7:0] t, output bit oe_seen, output bit oe_after);
      @(negedge clk); ack_n = 1'b0; #1 oe_seen = oe; t = data;
      @(negedge clk); #1 oe_seen &= oe;
      @(negedge clk); ack_n = 1'b1; #1 oe_after = oe;
      @(negedge clk); #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit         noisy, oe_s, oe_a;
      logic [7:0] t;
      logic [7:0] rem;
      logic [4:0] bhi;

      repeat (3) @(negedge clk);
      #1;
      check("R1 irq", irq, 0);
      check("R1 oe", oe, 0);
      check("R1 data", data, 0);
      rst_n = 1'b1;

      // R1 default base visible through a spurious handshake, R8 nothing pending
      hs_first(noisy);
      hs_second(t, oe_s, oe_a);
      check("R1 R8 spurious type", t, 8'h0F);
      check("R8 irq stays low", irq, 0);

      // R5 quiet first strobe and gap, drive only during second strobe
      raise(8'h04);
      check("R2 irq raised", irq, 1);
      repeat (3) @(negedge clk);
      #1 check("R2 irq held after req drop", irq, 1);
      hs_first(noisy);
      check("R5 bus quiet in first strobe and gap", noisy, 0);
      check("R2 irq held mid-handshake", irq, 1);
      hs_second(t, oe_s, oe_a);
      check("R5 oe during second strobe", oe_s, 1);
      check("R5 oe released", oe_a, 0);
      check("R3 type line2", t, 8'h0A);
      check("R7 irq drops", irq, 0);

      // R4 lower base bits ignored
      write_base(8'hA7);
      raise(8'h08);
      hs_first(noisy);
      hs_second(t, oe_s, oe_a);
      check("R4 base low bits ignored", t, 8'hA3);

      // R6 late request and late base write do not alter frozen type
      raise(8'h20);
      hs_first(noisy);
      raise(8'h02);
      write_base(8'h50);
      hs_second(t, oe_s, oe_a);
      check("R6 frozen winner and base", t, 8'hA5);
      check("R7 irq stays with another pending", irq, 1);
      hs_first(noisy);
      hs_second(t, oe_s, oe_a);
      check("R6 late line served next", t, 8'h51);
      check("R7 irq drops after last", irq, 0);

      // R3 R7 R9 exhaustive sweep of request patterns with varying base
      for (int m = 1; m < 256; m++) begin
         bhi = 5'(m * 7 + 3);
         write_base({bhi, 3'(m)});
         raise(8'(m));
         rem = 8'(m);
         check("R2 irq for pattern", irq, 1);
         while (rem != 0) begin
            int win = 0;
            for (int i = 7; i >= 0; i--) if (rem[i]) win = i;
            hs_first(noisy);
            hs_second(t, oe_s, oe_a);
            rem[win] = 1'b0;
            check("R3 R9 sweep type", t, {bhi, 3'(win)});
            check("R7 sweep irq", irq, (rem != 0) ? 1 : 0);
         end
      end

      // R8 spurious does not clear a line that arrives after the first strobe
      write_base(8'h08);
      hs_first(noisy);
      raise(8'h01);
      hs_second(t, oe_s, oe_a);
      check("R8 spurious with late req", t, 8'h0F);
      check("R8 late line kept pending", irq, 1);
      hs_first(noisy);
      hs_second(t, oe_s, oe_a);
      check("R8 late line served", t, 8'h08);
      check("R7 final irq", irq, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule